// File: doc/BRIEF.md
# Capture Sample FIFO with Sticky Loss Flag

This block buffers pulse-width samples from a capture channel until software collects them. It has seven entries, so the depth is not a power of two. A producer pushes a sample with a one-cycle strobe, and a consumer pops with its own strobe. The oldest stored sample is always visible on the head output. Full and empty flags report how many entries are occupied. When a sample arrives while all seven entries are occupied, that sample is lost, and a sticky loss flag records the loss.

A single clear pulse puts the block back to its starting condition in one step: it empties the storage and lowers the loss flag together. Everything runs on one clock. The active-low reset asserts asynchronously and is released through an internal two-stage synchronizer, so the block comes out of reset two clock edges after `rst_n` rises.

Top module: `pw_sample_fifo`

## Requirements
- R1: After reset the block reports empty_o=1, full_o=0, drop_o=0 and head_o=0.
- R2: Samples leave in the order they were pushed, and head_o shows the oldest stored sample one cycle after the edge that stored it or removed its predecessor.
- R3: full_o is 1 exactly when 7 samples are stored, empty_o is 1 exactly when none are stored, and the two are never 1 together.
- R4: A push while the FIFO is full, without a pop in the same cycle, discards the sample, leaves the stored contents unchanged and sets drop_o.
- R5: drop_o stays 1 through any number of pushes and pops until a clear.
- R6: A clear empties the FIFO and drops drop_o to 0 on the same edge, and it overrides a push or pop in the same cycle.
- R7: A pop while empty is ignored, so the next pushed sample becomes the head and one pop empties the FIFO again.
- R8: A push together with a pop while full both take effect: the FIFO stays full, the head advances and drop_o does not change.
- R9: The storage indices wrap from the last entry back to the first, so ordering holds across any number of passes through the storage.
- R10: head_o reads 0 whenever empty_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store push_data_i this cycle |
| push_data_i | input | DATA_W | Sample to store |
| pop_i | input | 1 | Remove the head sample this cycle |
| clear_i | input | 1 | Empty the FIFO and lower the loss flag |
| head_o | output | DATA_W | Oldest stored sample, 0 when empty |
| full_o | output | 1 | All 7 entries occupied |
| empty_o | output | 1 | No entry occupied |
| drop_o | output | 1 | Sticky: a sample was discarded while full |

## Verification
A wrong occupancy count shows at the ports one cycle after the edge that corrupts it. It appears as a full or empty flag that arrives one push or pop too early or too late. A read index that wraps wrongly or moves on an ignored pop shows up as a head value out of order on the next pop. A drop flag that fails to stick, or that is raised by a same-cycle push and pop at full, is visible on drop_o on the edge after the event. The test sequence runs the indices past the end of the storage so that each of these faults surfaces within a few samples.

// File: rtl/pw_fifo_pkg.sv
`timescale 1ns/1ps
package pw_fifo_pkg;
  parameter int unsigned PW_DEPTH_DEF  = 7;
  parameter int unsigned PW_DATA_W_DEF = 16;
endpackage

// File: rtl/pw_fifo_rstsync.sv
`timescale 1ns/1ps
module pw_fifo_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pw_fifo_ctrl.sv
`timescale 1ns/1ps
module pw_fifo_ctrl #(
  parameter int unsigned DEPTH = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic                     clear_i,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_ptr_o,
  output logic [$clog2(DEPTH)-1:0] rd_ptr_o,
  output logic                     full_o,
  output logic                     empty_o,
  output logic                     reject_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             pop_ok, push_ok, upd_en;

  function automatic logic [PTR_W-1:0] step_idx(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  always_comb begin
    pop_ok   = pop_i && !empty_o && !clear_i;
    push_ok  = push_i && !clear_i && (!full_o || pop_ok);
    reject_o = push_i && !clear_i && full_o && !pop_ok;
    upd_en   = clear_i || push_ok || pop_ok;
    if (clear_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      wr_ptr_d = push_ok ? step_idx(wr_ptr_q) : wr_ptr_q;
      rd_ptr_d = pop_ok  ? step_idx(rd_ptr_q) : rd_ptr_q;
      count_d  = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (upd_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  assign wr_en_o  = push_ok;
  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;

  // R3
  full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_q <= LAST_IDX) && (rd_ptr_q <= LAST_IDX));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o && pop_i && !push_i && !clear_i |=> empty_o && $stable(rd_ptr_q));
  // R8
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && push_i && pop_i && !clear_i |=> full_o && (rd_ptr_q != $past(rd_ptr_q)));
  // R6
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> empty_o && !full_o);
endmodule

// File: rtl/pw_fifo_store.sv
`timescale 1ns/1ps
module pw_fifo_store #(
  parameter int unsigned DEPTH  = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_ptr_i,
  input  logic [$clog2(DEPTH)-1:0] rd_ptr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     empty_i,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DEPTH*DATA_W-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [DATA_W-1:0] entry_q;
    logic              entry_we;
    assign entry_we = wr_en_i && (wr_ptr_i == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (entry_we) entry_q <= wdata_i;
    end
    assign flat[i*DATA_W +: DATA_W] = entry_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!empty_i && (rd_ptr_i == PTR_W'(k))) rdata_o = flat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pw_fifo_dropflag.sv
`timescale 1ns/1ps
module pw_fifo_dropflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic drop_o
);
  logic drop_q, drop_d, drop_en;

  always_comb begin
    drop_en = set_i || clr_i;
    drop_d  = !clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_q <= 1'b0;
    else if (drop_en) drop_q <= drop_d;
  end

  assign drop_o = drop_q;

  // R5
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o && !clr_i |=> drop_o);
  // R6
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !drop_o);
endmodule

// File: rtl/pw_sample_fifo.sv
`timescale 1ns/1ps
module pw_sample_fifo
  import pw_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = PW_DEPTH_DEF,
  parameter int unsigned DATA_W = PW_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              drop_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic             rst_sync_n;
  logic             wr_en, reject;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  pw_fifo_rstsync #(.STAGES(2)) u_rstsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pw_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .push_i(push_i), .pop_i(pop_i),
    .clear_i(clear_i), .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .full_o(full_o), .empty_o(empty_o), .reject_o(reject)
  );

  pw_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .wdata_i(push_data_i), .empty_i(empty_o), .rdata_o(head_o)
  );

  pw_fifo_dropflag u_drop (
    .clk(clk), .rst_n(rst_sync_n), .set_i(reject), .clr_i(clear_i),
    .drop_o(drop_o)
  );

  // R4
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full_o && push_i && !pop_i && !clear_i |=> drop_o && full_o && $stable(head_o));
  // R8
  swap_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full_o && push_i && pop_i && !clear_i && !drop_o |=> !drop_o);
  // R10
  head_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    empty_o |-> (head_o == '0));
endmodule

// File: tb/pw_sample_fifo_bench.sv
`timescale 1ns/1ps
module pw_sample_fifo_bench;
  localparam int DW = 8;
  localparam int NV = 10;
  // vector: push,pop,clear,data[7:0],exp_full,exp_empty,exp_drop,exp_head[7:0]
  localparam logic [21:0] VEC [NV] = '{
    {3'b100, 8'h11, 3'b000, 8'h11},  // R2
    {3'b100, 8'h22, 3'b000, 8'h11},  // R2
    {3'b010, 8'h00, 3'b000, 8'h22},  // R2
    {3'b110, 8'h33, 3'b000, 8'h33},  // R2 push+pop at one entry
    {3'b010, 8'h00, 3'b010, 8'h00},  // R3 R10
    {3'b010, 8'h00, 3'b010, 8'h00},  // R7 pop while empty
    {3'b100, 8'h44, 3'b000, 8'h44},  // R7
    {3'b111, 8'h55, 3'b010, 8'h00},  // R6 clear wins
    {3'b100, 8'h66, 3'b000, 8'h66},  // R6
    {3'b010, 8'h00, 3'b010, 8'h00}   // R7
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i, pop_i, clear_i;
  logic [DW-1:0] push_data_i;
  logic [DW-1:0] head_o;
  logic          full_o, empty_o, drop_o;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  always #2.5 clk = ~clk;

  pw_sample_fifo #(.DEPTH(7), .DATA_W(DW)) u_pw_sample_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .clear_i(clear_i), .head_o(head_o), .full_o(full_o),
    .empty_o(empty_o), .drop_o(drop_o)
  );

  task automatic expect_state(input string req, input bit ef, input bit ee,
                              input bit ed, input logic [DW-1:0] eh);
    checks++;
    if (full_o !== ef || empty_o !== ee || drop_o !== ed || head_o !== eh) begin
      fails++;
      $display("FAIL %s: full/empty/drop/head actual %b/%b/%b/%h expected %b/%b/%b/%h",
               req, full_o, empty_o, drop_o, head_o, ef, ee, ed, eh);
    end
  endtask

  task automatic step(input bit pu, input bit po, input bit cl, input logic [DW-1:0] d);
    @(negedge clk);
    push_i = pu; pop_i = po; clear_i = cl; push_data_i = d;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; clear_i = 1'b0; push_data_i = '0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; clear_i = 1'b0; push_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_state("R1 reset", 1'b0, 1'b1, 1'b0, 8'h00);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18:11]);
      expect_state($sformatf("R2/R6/R7 vector %0d", v), VEC[v][10], VEC[v][9],
                   VEC[v][8], VEC[v][7:0]);
    end

    // R3 fill to seven; indices already moved, so this wraps (R9)
    for (int k = 0; k < 7; k++) begin
      step(1'b1, 1'b0, 1'b0, 8'hA0 + 8'(k));
      expect_state($sformatf("R3 fill %0d", k + 1), (k == 6), 1'b0, 1'b0, 8'hA0);
    end

    // R8 push and pop together while full
    step(1'b1, 1'b1, 1'b0, 8'hB7);
    expect_state("R8 swap at full", 1'b1, 1'b0, 1'b0, 8'hA1);

    // R4 push while full is discarded
    step(1'b1, 1'b0, 1'b0, 8'hEE);
    expect_state("R4 push at full", 1'b1, 1'b0, 1'b1, 8'hA1);

    // R5 drain, drop stays set; R9 order across wrap
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b1, 1'b0, 8'h00);
      expect_state($sformatf("R5 R9 drain %0d", k), 1'b0, 1'b0, 1'b1, 8'hA2 + 8'(k));
    end
    step(1'b0, 1'b1, 1'b0, 8'h00);
    expect_state("R9 wrapped sample", 1'b0, 1'b0, 1'b1, 8'hB7);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    expect_state("R5 R10 drained", 1'b0, 1'b1, 1'b1, 8'h00);

    // R7 pop on empty leaves drop and emptiness alone
    step(1'b0, 1'b1, 1'b0, 8'h00);
    expect_state("R7 pop empty", 1'b0, 1'b1, 1'b1, 8'h00);

    // R5 pushes do not lower drop
    step(1'b1, 1'b0, 1'b0, 8'h5A);
    expect_state("R5 push keeps drop", 1'b0, 1'b0, 1'b1, 8'h5A);

    // R6 clear lowers drop and empties together
    step(1'b0, 1'b0, 1'b1, 8'h00);
    expect_state("R6 clear", 1'b0, 1'b1, 1'b0, 8'h00);

    step(1'b1, 1'b0, 1'b0, 8'hC3);
    expect_state("R2 after clear", 1'b0, 1'b0, 1'b0, 8'hC3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule